// File: doc/BRIEF.md
# Bus-Shared GPIO Port Pin Multiplexer

This block is an eight-pin general-purpose I/O port whose pins double as external-bus control lines. Software writes a direction register and an output data register over a small register bus. A fixed per-pin rule then decides whether each pin carries a bus-control signal, drives GPIO data, or is left undriven as an input. The operating mode input selects between single-chip operation, where every pin is plain GPIO, and expanded operation, where the bus functions can take over.

Enables from the bus controller (address-strobe enable, low-write enable, two chip-select enables and the wait enable) gate the takeover of their pins. Two pins carry the read and high-write strobes unconditionally in expanded mode, and the top pin can present the system clock, controlled by its own direction bit. Pin levels pass through a two-stage synchronizer before software can read them, and the raw level of pin 0 is handed to the bus controller as the wait request while the wait function is active.

Top module: `busmux_gpio_port`

## Requirements
- R1: While reset is asserted, direction bits 6..0 and every output data bit are 0, and direction bit 7 takes the value of `expanded_i`; a pin with direction 0 and no bus function has `pin_oe_o` = 0.
- R2: The direction register (address 0) is write-only: a read of address 0, and of unused address 3, returns 8'h00.
- R3: A pin acting as GPIO has `pin_oe_o` equal to its direction bit, and `pin_out_o` equal to its output data bit when that bit is 1 and 0 otherwise.
- R4: In expanded mode with direction bit 7 set to 1, pin 7 drives `sysclk_i` with the output enable on; with bit 7 at 0, the pin is an input.
- R5: In expanded mode with `strobe_en_i` = 1, pin 6 drives `as_i` with its output enable on, whatever its direction bit holds.
- R6: In expanded mode, pin 5 drives `rd_i` and pin 4 drives `hwr_i`, both enabled, whatever their direction bits hold.
- R7: In expanded mode with `lowwr_en_i` = 1, pin 3 drives `lwr_i` with its output enable on.
- R8: In expanded mode, pin 2 drives `cs_i[1]` when `cs_en_i[1]` = 1 and pin 1 drives `cs_i[0]` when `cs_en_i[0]` = 1; a chip-select pin whose enable is 0 is GPIO.
- R9: In expanded mode with `wait_en_i` = 1, pin 0 has `pin_oe_o[0]` = 0 and `pin_out_o[0]` = 0, and `wait_o` equals `pin_in_i[0]`; otherwise `wait_o` is 0.
- R10: A read of address 2 returns the pin levels as they were two rising clock edges earlier.
- R11: In single-chip mode (`expanded_i` = 0) every bus enable is ignored and all eight pins follow the GPIO rule of R3.
- R12: The output data register (address 1) is readable and returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| expanded_i | input | 1 | 1 = expanded mode, 0 = single-chip mode |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 direction, 1 output data, 2 pin levels |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, 0 when no read is selected |
| strobe_en_i | input | 1 | Address-strobe output enable |
| lowwr_en_i | input | 1 | Low-write strobe output enable |
| cs_en_i | input | 2 | Chip-select output enables for pins 2 and 1 |
| wait_en_i | input | 1 | Wait input function enable |
| sysclk_i | input | 1 | Clock level presented on pin 7 |
| as_i | input | 1 | Address strobe from the bus controller |
| rd_i | input | 1 | Read strobe |
| hwr_i | input | 1 | High-byte write strobe |
| lwr_i | input | 1 | Low-byte write strobe |
| cs_i | input | 2 | Chip selects for pins 2 and 1 |
| pin_in_i | input | 8 | Pad input levels |
| pin_out_o | output | 8 | Pad drive values |
| pin_oe_o | output | 8 | Pad output enables |
| wait_o | output | 1 | Wait request toward the bus controller |

## Verification
The hardest situation to reach is a pin whose bus enable is set while the port is in single-chip mode or while the direction bit disagrees with the bus function, because each pin has its own override rule and the enables, mode and registers must all line up. The stimulus draws mode, every enable, every strobe and both registers at random from a fixed seed on each step, so all combinations of override and fallback occur on every pin, and directed cases pin down the reset value by mode, the write-only read and the two-edge synchronizer latency.

// File: rtl/busmux_gpio_pkg.sv
package busmux_gpio_pkg;

    typedef enum logic [1:0] {
        ROLE_CLOCK = 2'd0,
        ROLE_GATED = 2'd1,
        ROLE_FIXED = 2'd2,
        ROLE_INPUT = 2'd3
    } pin_role_e;

    typedef enum logic [1:0] {
        ADDR_DIR   = 2'd0,
        ADDR_DATA  = 2'd1,
        ADDR_LEVEL = 2'd2,
        ADDR_NONE  = 2'd3
    } reg_addr_e;

    // Fixed role of each pin of the port
    function automatic pin_role_e role_of(input int idx);
        case (idx)
            7:       return ROLE_CLOCK;
            5, 4:    return ROLE_FIXED;
            0:       return ROLE_INPUT;
            default: return ROLE_GATED;
        endcase
    endfunction

endpackage

// File: rtl/bgp_sync.sv
module bgp_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/bgp_regs.sv
module bgp_regs
    import busmux_gpio_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          expanded_i,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [W-1:0]  level_i,
    output logic [W-1:0]  rdata_o,
    output logic [W-1:0]  dir_o,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] dir_q;
    logic [W-1:0] data_q;
    reg_addr_e    dec_addr;
    logic         do_wr;
    logic         do_rd;

    assign dec_addr = reg_addr_e'(addr_i[1:0]);
    assign do_wr    = sel_i & wr_i;
    assign do_rd    = sel_i & ~wr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q       <= '0;
            dir_q[W-1]  <= expanded_i;
            data_q      <= '0;
        end else if (do_wr) begin
            if (dec_addr == ADDR_DIR)  dir_q  <= wdata_i;
            if (dec_addr == ADDR_DATA) data_q <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (do_rd) begin
            unique case (dec_addr)
                ADDR_DIR:   rdata_o = '0;
                ADDR_DATA:  rdata_o = data_q;
                ADDR_LEVEL: rdata_o = level_i;
                ADDR_NONE:  rdata_o = '0;
            endcase
        end
    end

    assign dir_o  = dir_q;
    assign data_o = data_q;

    // R2: the direction register never reads back
    a_r2_dir_unreadable: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && dec_addr == ADDR_DIR) |-> (rdata_o == '0));
endmodule

// File: rtl/bgp_pin_cell.sv
module bgp_pin_cell
    import busmux_gpio_pkg::*;
#(
    parameter pin_role_e ROLE = ROLE_GATED
) (
    input  logic expanded_i,
    input  logic en_i,
    input  logic alt_i,
    input  logic dir_i,
    input  logic data_i,
    output logic out_o,
    output logic oe_o
);
    logic take_alt;

    // Clock pin additionally needs its direction bit; others only mode and enable
    assign take_alt = expanded_i & en_i & ((ROLE != ROLE_CLOCK) | dir_i);

    always_comb begin
        if (take_alt) begin
            if (ROLE == ROLE_INPUT) begin
                out_o = 1'b0;
                oe_o  = 1'b0;
            end else begin
                out_o = alt_i;
                oe_o  = 1'b1;
            end
        end else begin
            out_o = dir_i & data_i;
            oe_o  = dir_i;
        end
    end
endmodule

// File: rtl/busmux_gpio_port.sv
module busmux_gpio_port
    import busmux_gpio_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expanded_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [PORT_W-1:0] bus_wdata_i,
    output logic [PORT_W-1:0] bus_rdata_o,
    input  logic              strobe_en_i,
    input  logic              lowwr_en_i,
    input  logic [1:0]        cs_en_i,
    input  logic              wait_en_i,
    input  logic              sysclk_i,
    input  logic              as_i,
    input  logic              rd_i,
    input  logic              hwr_i,
    input  logic              lwr_i,
    input  logic [1:0]        cs_i,
    input  logic [PORT_W-1:0] pin_in_i,
    output logic [PORT_W-1:0] pin_out_o,
    output logic [PORT_W-1:0] pin_oe_o,
    output logic              wait_o
);
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] data_q;
    logic [PORT_W-1:0] level_q;
    logic [7:0]        pin_en;
    logic [7:0]        pin_alt;

    assign pin_en  = {1'b1, strobe_en_i, 1'b1, 1'b1, lowwr_en_i,
                      cs_en_i[1], cs_en_i[0], wait_en_i};
    assign pin_alt = {sysclk_i, as_i, rd_i, hwr_i, lwr_i, cs_i[1], cs_i[0], 1'b0};

    bgp_sync #(.W(PORT_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in_i),
        .q_o   (level_q)
    );

    bgp_regs #(.W(PORT_W), .AW(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .expanded_i (expanded_i),
        .sel_i      (bus_sel_i),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .level_i    (level_q),
        .rdata_o    (bus_rdata_o),
        .dir_o      (dir_q),
        .data_o     (data_q)
    );

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        bgp_pin_cell #(.ROLE(role_of(i))) u_cell (
            .expanded_i (expanded_i),
            .en_i       (pin_en[i % 8]),
            .alt_i      (pin_alt[i % 8]),
            .dir_i      (dir_q[i]),
            .data_i     (data_q[i]),
            .out_o      (pin_out_o[i]),
            .oe_o       (pin_oe_o[i])
        );
    end

    assign wait_o = expanded_i & wait_en_i & pin_in_i[0];

    // Edges since reset, saturating, for the synchronizer check
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R6: read and high-write strobes own pins 5 and 4 in expanded mode
    a_r6_fixed_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        expanded_i |-> (pin_oe_o[5] && pin_oe_o[4] &&
                        pin_out_o[5] == rd_i && pin_out_o[4] == hwr_i));

    // R9: the wait pin is never driven while waiting is enabled
    a_r9_wait_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (expanded_i && wait_en_i) |-> !pin_oe_o[0]);

    // R11: single-chip mode enables follow the direction register alone
    a_r11_single_chip_gpio: assert property (@(posedge clk) disable iff (!rst_n)
        !expanded_i |-> (pin_oe_o == dir_q && pin_out_o == (dir_q & data_q)));

    // R10: level register lags the pads by two edges
    a_r10_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (level_q == $past(pin_in_i, 2)));

    // R4: clock pin presents the clock when its direction bit is set
    a_r4_clock_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (expanded_i && dir_q[7]) |-> (pin_oe_o[7] && pin_out_o[7] == sysclk_i));
endmodule

// File: tb/tb_busmux_gpio_port.sv
module tb_busmux_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       expanded_i;
    logic       bus_sel_i, bus_wr_i;
    logic [1:0] bus_addr_i;
    logic [7:0] bus_wdata_i, bus_rdata_o;
    logic       strobe_en_i, lowwr_en_i, wait_en_i;
    logic [1:0] cs_en_i, cs_i;
    logic       sysclk_i, as_i, rd_i, hwr_i, lwr_i;
    logic [7:0] pin_in_i, pin_out_o, pin_oe_o;
    logic       wait_o;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_dir, m_data;

    always #10 clk = ~clk;

    busmux_gpio_port dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_pins();
        logic [7:0] o, e;
        o = m_dir & m_data;
        e = m_dir;
        if (expanded_i) begin
            if (m_dir[7])     begin o[7] = sysclk_i; e[7] = 1'b1; end
            if (strobe_en_i)  begin o[6] = as_i;     e[6] = 1'b1; end
            o[5] = rd_i;  e[5] = 1'b1;
            o[4] = hwr_i; e[4] = 1'b1;
            if (lowwr_en_i)   begin o[3] = lwr_i;    e[3] = 1'b1; end
            if (cs_en_i[1])   begin o[2] = cs_i[1];  e[2] = 1'b1; end
            if (cs_en_i[0])   begin o[1] = cs_i[0];  e[1] = 1'b1; end
            if (wait_en_i)    begin o[0] = 1'b0;     e[0] = 1'b0; end
        end
        return {e, o};
    endfunction

    task automatic check_pins(input string tag);
        logic [15:0] m;
        m = model_pins();
        chk({tag, " oe"},  pin_oe_o,  m[15:8]);
        chk({tag, " out"}, pin_out_o, m[7:0]);
        chk({tag, " wait"}, wait_o, expanded_i & wait_en_i & pin_in_i[0]);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(posedge clk);
        #1;
        if (a == 2'd0) m_dir = d;
        if (a == 2'd1) m_data = d;
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
        #1 d = bus_rdata_o;
        bus_sel_i = 1'b0;
    endtask

    task automatic quiet();
        strobe_en_i = 0; lowwr_en_i = 0; cs_en_i = 0; wait_en_i = 0;
        sysclk_i = 0; as_i = 0; rd_i = 0; hwr_i = 0; lwr_i = 0; cs_i = 0;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; expanded_i = mode;
        m_dir = {mode, 7'd0}; m_data = 8'h00;
        #1;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd4242));
        rst_n = 1'b0; expanded_i = 1'b1;
        bus_sel_i = 0; bus_wr_i = 0; bus_addr_i = 0; bus_wdata_i = 0;
        pin_in_i = 8'h00;
        quiet();

        // R1: reset in expanded mode: bit 7 set, strobes 5/4 driven
        do_reset(1'b1);
        chk("R1 expanded reset oe", pin_oe_o, 8'hB0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        reg_read(2'd1, rd);
        chk("R1 data reset", rd, 8'h00);
        // R2: write-only direction register and unused address
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, rd);
        chk("R2 dir read", rd, 8'h00);
        reg_read(2'd3, rd);
        chk("R2 unused read", rd, 8'h00);

        // R1: reset in single-chip mode: nothing driven
        do_reset(1'b0);
        chk("R1 single-chip reset oe", pin_oe_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: data register readback
        reg_write(2'd1, 8'h3C);
        reg_read(2'd1, rd);
        chk("R12 data readback", rd, 8'h3C);

        // R3: GPIO drive and tri-state in single-chip mode
        reg_write(2'd0, 8'h0F);
        #1 chk("R3 gpio oe", pin_oe_o, 8'h0F);
        chk("R3 gpio out", pin_out_o, 8'h0C);

        // R11: enables ignored in single-chip mode
        @(negedge clk);
        strobe_en_i = 1; lowwr_en_i = 1; cs_en_i = 2'b11; wait_en_i = 1;
        as_i = 1; rd_i = 1; hwr_i = 1; lwr_i = 1; cs_i = 2'b11; sysclk_i = 1;
        reg_write(2'd0, 8'hFF);
        reg_write(2'd1, 8'h5A);
        #1 chk("R11 single-chip oe", pin_oe_o, 8'hFF);
        chk("R11 single-chip out", pin_out_o, 8'h5A);

        // Expanded mode directed cases
        @(negedge clk);
        expanded_i = 1; quiet();
        reg_write(2'd0, 8'h00);
        rd_i = 1; hwr_i = 0;
        #1 chk("R6 strobes oe", pin_oe_o[5:4], 2'b11);
        chk("R6 strobes out", pin_out_o[5:4], 2'b10);
        chk("R4 clock pin input", pin_oe_o[7], 1'b0);
        reg_write(2'd0, 8'h80);
        sysclk_i = 1; #1 chk("R4 clock high", pin_out_o[7], 1'b1);
        sysclk_i = 0; #1 chk("R4 clock low", pin_out_o[7], 1'b0);
        strobe_en_i = 1; as_i = 1;
        #1 chk("R5 address strobe", {pin_oe_o[6], pin_out_o[6]}, 2'b11);
        lowwr_en_i = 1; lwr_i = 1;
        #1 chk("R7 low write", {pin_oe_o[3], pin_out_o[3]}, 2'b11);
        cs_en_i = 2'b10; cs_i = 2'b11;
        #1 chk("R8 chip select pin2", {pin_oe_o[2], pin_out_o[2]}, 2'b11);
        chk("R8 chip select pin1 fallback", pin_oe_o[1], 1'b0);
        reg_write(2'd0, 8'h01);
        reg_write(2'd1, 8'h01);
        wait_en_i = 1; pin_in_i = 8'h01;
        #1 chk("R9 wait pin oe", pin_oe_o[0], 1'b0);
        chk("R9 wait out", wait_o, 1'b1);
        wait_en_i = 0;
        #1 chk("R9 wait off gpio", {pin_oe_o[0], wait_o}, 2'b10);

        // R10: two-edge synchronizer latency
        @(negedge clk);
        pin_in_i = 8'h00;
        repeat (3) @(negedge clk);
        pin_in_i = 8'hA5;
        bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = 2'd2;
        #1 chk("R10 level edge0", bus_rdata_o, 8'h00);
        @(negedge clk);
        chk("R10 level edge1", bus_rdata_o, 8'h00);
        @(negedge clk);
        chk("R10 level edge2", bus_rdata_o, 8'hA5);
        bus_sel_i = 0;

        // Random mix across modes, enables, strobes and registers
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            expanded_i  = ($urandom % 4) != 0;
            strobe_en_i = $urandom; lowwr_en_i = $urandom;
            cs_en_i = $urandom; wait_en_i = $urandom;
            sysclk_i = $urandom; as_i = $urandom; rd_i = $urandom;
            hwr_i = $urandom; lwr_i = $urandom; cs_i = $urandom;
            pin_in_i = $urandom;
            if (($urandom % 3) == 0) reg_write(2'($urandom % 2), 8'($urandom));
            #1 check_pins("R3 random mux");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule